// File: doc/BRIEF.md
# DMA page address translator

This block sits between DMA-capable devices and the system bus. It turns a 24-bit device address into a 32-bit system bus address. The device space is cut into 2048 pages of 8 KB. An on-chip table holds one 32-bit descriptor per page and supplies the physical page number, two caching attributes, a write-protect flag and a type code. The low 13 address bits pass straight through as the page offset.

Software fills the table through a word-wide CPU port indexed by page number. Devices issue an address, a write flag and a request strobe. One cycle later the block answers with either a translated address and its attributes, or a one-cycle fault pulse. A device with a narrow address bus is placed at the top of the 24-bit space: a width input forces the address bits it cannot drive to one before lookup. Each successful access records usage in its descriptor, and a successful write also records modification.

Top module: `iotr_xlate`

## Requirements
- R1: After a synchronous active-low reset, `res_valid`, `res_fault`, `res_addr`, `res_ci`, `res_bx` and `cpu_rdata` are zero. Every descriptor reads as zero, so every DMA access faults until software writes the table.
- R2: A request in cycle n yields its result in cycle n+1. On success `res_valid` is 1 and `res_addr` = {descriptor bits 31..13, folded address bits 12..0}. The page index is folded address bits 23..13.
- R3: Only the type code 01 in descriptor bits 1..0 is valid. Codes 00, 10 and 11 make any access give `res_fault`=1 and `res_valid`=0. The two are never 1 together.
- R4: When descriptor bit 2 (write protect) is set, a write (`dma_wr`=1) faults and a read still translates.
- R5: On success, `res_ci` carries descriptor bit 6 and `res_bx` carries descriptor bit 5.
- R6: For a device width W on `dev_aw`, address bits W..23 are forced to one before lookup. Values of 24 or more force nothing, and values below 13 act as 13, so the offset is never altered.
- R7: A successful access sets descriptor bit 3 (used). A successful write also sets bit 4 (modified). A read leaves bit 4 unchanged.
- R8: A faulting access changes no descriptor bit.
- R9: When a CPU write and a status write-back target the same descriptor in one cycle, the descriptor afterwards holds exactly the CPU data. The DMA result of that cycle uses the old descriptor.
- R10: A CPU write (`cpu_sel`=1, `cpu_we`=1) stores `cpu_wdata` at `cpu_idx`. A CPU read (`cpu_sel`=1, `cpu_we`=0) returns the entry on `cpu_rdata` in the next cycle, and `cpu_rdata` holds that value until the next read.
- R11: A request is accepted every cycle. Back-to-back requests each produce their own result in order, and each one sees the status updates of the request before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel | input | 1 | CPU access strobe |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_idx | input | 11 | Descriptor index |
| cpu_wdata | input | 32 | Descriptor write data |
| cpu_rdata | output | 32 | Descriptor read data, one cycle after a read |
| dma_req | input | 1 | DMA request strobe |
| dma_wr | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | 24 | Device address |
| dev_aw | input | 5 | Device address width in bits |
| res_valid | output | 1 | Translation succeeded |
| res_fault | output | 1 | Access refused |
| res_addr | output | 32 | Translated system bus address |
| res_ci | output | 1 | Cache-inhibit attribute |
| res_bx | output | 1 | Full-block attribute |

## Verification
Two functions can land on the same descriptor in one cycle: the status write-back of a successful DMA access, and a CPU write. The bench forces this on purpose. In one cycle it drives a DMA write to a valid page and a CPU write of a new descriptor with the used and modified bits clear to that same page. It then checks that the DMA result reflects the old mapping and that a CPU read-back returns the CPU data with no status bits merged in. Random traffic that mixes CPU writes with DMA requests on a small pool of pages also hits this collision now and then, and a bench reference table judges each case.

// File: rtl/iotr_pkg.sv
// Package: shared constants and descriptor field positions for the DMA
// page translator. Assumes a 32-bit descriptor with the page number in
// the upper bits and the flags in the low byte.
package iotr_pkg;
    localparam int DESC_W   = 32;
    localparam int PAGE_SH  = 13;
    localparam int PPN_W    = DESC_W - PAGE_SH;
    localparam int BIT_WP   = 2;
    localparam int BIT_USED = 3;
    localparam int BIT_MOD  = 4;
    localparam int BIT_BX   = 5;
    localparam int BIT_CI   = 6;
    localparam logic [1:0] DT_VALID = 2'b01;
endpackage

// File: rtl/iotr_fold.sv
// iotr_fold: places a narrow device at the top of the device space.
// Index bits at or above the device width are forced to one. Offset bits
// are never touched, so widths below the page shift act as the page shift.
module iotr_fold #(
    parameter int DVA_W   = 24,
    parameter int PAGE_SH = 13,
    parameter int AW_W    = 5
) (
    input  logic [DVA_W-1:0] addr_in,
    input  logic [AW_W-1:0]  dev_aw,
    output logic [DVA_W-1:0] addr_out
);
    // offset bits pass straight through
    assign addr_out[PAGE_SH-1:0] = addr_in[PAGE_SH-1:0];

    genvar gi;
    generate
        for (gi = PAGE_SH; gi < DVA_W; gi++) begin : g_idx
            localparam logic [AW_W-1:0] POS = AW_W'(gi);
            // force this index bit high when the device cannot drive it
            assign addr_out[gi] = addr_in[gi] | (dev_aw <= POS);
        end
    endgenerate
endmodule

// File: rtl/iotr_perm.sv
// iotr_perm: decides whether an access to a descriptor is allowed.
// Assumes the type code and write-protect flag come from the selected entry.
module iotr_perm (
    input  logic [1:0] dt,
    input  logic       wp,
    input  logic       wr,
    output logic       fault
);
    // only type 01 is valid; write protect refuses writes
    always_comb begin
        fault = (dt != iotr_pkg::DT_VALID) || (wr && wp);
    end
endmodule

// File: rtl/iotr_desc_table.sv
// iotr_desc_table: holds one descriptor per page. Serves CPU reads and
// writes and a combinational lookup port, and writes back the used and
// modified flags. A CPU write to the same entry in the same cycle wins.
// Assumes all entries clear on reset.
module iotr_desc_table #(
    parameter int IDX_W = 11
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_sel,
    input  logic                         cpu_we,
    input  logic [IDX_W-1:0]             cpu_idx,
    input  logic [iotr_pkg::DESC_W-1:0]  cpu_wdata,
    output logic [iotr_pkg::DESC_W-1:0]  cpu_rdata,
    input  logic [IDX_W-1:0]             lk_idx,
    output logic [iotr_pkg::PPN_W-1:0]   lk_ppn,
    output logic                         lk_ci,
    output logic                         lk_bx,
    output logic                         lk_wp,
    output logic [1:0]                   lk_dt,
    input  logic                         upd_en,
    input  logic                         upd_mod
);
    import iotr_pkg::*;
    localparam int N_ENT = 1 << IDX_W;

    logic [DESC_W-1:0] tbl [N_ENT];
    logic              cpu_wr;
    logic              cpu_hit;

    assign cpu_wr  = cpu_sel && cpu_we;
    assign cpu_hit = cpu_wr && (cpu_idx == lk_idx);

    // lookup port: fields of the selected entry
    assign lk_ppn = tbl[lk_idx][DESC_W-1:PAGE_SH];
    assign lk_ci  = tbl[lk_idx][BIT_CI];
    assign lk_bx  = tbl[lk_idx][BIT_BX];
    assign lk_wp  = tbl[lk_idx][BIT_WP];
    assign lk_dt  = tbl[lk_idx][1:0];

    // table storage: reset clear, status write-back, CPU write last so it wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) tbl[i] <= '0;
        end else begin
            if (upd_en && !cpu_hit) begin
                tbl[lk_idx][BIT_USED] <= 1'b1;
                if (upd_mod) tbl[lk_idx][BIT_MOD] <= 1'b1;
            end
            if (cpu_wr) tbl[cpu_idx] <= cpu_wdata;
        end
    end

    // CPU read data register, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)                  cpu_rdata <= '0;
        else if (cpu_sel && !cpu_we) cpu_rdata <= tbl[cpu_idx];
    end

    // R9: CPU data lands unaltered even when a write-back collides
    a_r9_cpu_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> tbl[$past(cpu_idx)] == $past(cpu_wdata));

    // R7: a write-back with no colliding CPU write leaves the used flag set
    a_r7_used_set: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !cpu_hit && !cpu_wr) |=> tbl[$past(lk_idx)][BIT_USED]);
endmodule

// File: rtl/iotr_xlate.sv
// iotr_xlate: DMA page address translator top. Folds the device address,
// looks up the page descriptor, checks permission and registers the
// result one cycle later. Assumes one request per cycle at most and no
// back-pressure on the result.
module iotr_xlate #(
    parameter int DVA_W = 24,
    parameter int AW_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_sel,
    input  logic                         cpu_we,
    input  logic [DVA_W-iotr_pkg::PAGE_SH-1:0] cpu_idx,
    input  logic [iotr_pkg::DESC_W-1:0]  cpu_wdata,
    output logic [iotr_pkg::DESC_W-1:0]  cpu_rdata,
    input  logic                         dma_req,
    input  logic                         dma_wr,
    input  logic [DVA_W-1:0]             dma_addr,
    input  logic [AW_W-1:0]              dev_aw,
    output logic                         res_valid,
    output logic                         res_fault,
    output logic [iotr_pkg::DESC_W-1:0]  res_addr,
    output logic                         res_ci,
    output logic                         res_bx
);
    import iotr_pkg::*;
    localparam int IDX_W = DVA_W - PAGE_SH;

    logic [DVA_W-1:0] f_addr;
    logic [IDX_W-1:0] lk_idx;
    logic [PPN_W-1:0] lk_ppn;
    logic             lk_ci, lk_bx, lk_wp;
    logic [1:0]       lk_dt;
    logic             deny;
    logic             upd_en;

    iotr_fold #(.DVA_W(DVA_W), .PAGE_SH(PAGE_SH), .AW_W(AW_W)) u_fold (
        .addr_in (dma_addr),
        .dev_aw  (dev_aw),
        .addr_out(f_addr)
    );

    assign lk_idx = f_addr[DVA_W-1:PAGE_SH];

    iotr_desc_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_sel  (cpu_sel),
        .cpu_we   (cpu_we),
        .cpu_idx  (cpu_idx),
        .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .lk_idx   (lk_idx),
        .lk_ppn   (lk_ppn),
        .lk_ci    (lk_ci),
        .lk_bx    (lk_bx),
        .lk_wp    (lk_wp),
        .lk_dt    (lk_dt),
        .upd_en   (upd_en),
        .upd_mod  (dma_wr)
    );

    iotr_perm u_perm (
        .dt   (lk_dt),
        .wp   (lk_wp),
        .wr   (dma_wr),
        .fault(deny)
    );

    assign upd_en = dma_req && !deny;

    // result register: one-cycle latency, fault and valid exclusive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_fault <= 1'b0;
            res_addr  <= '0;
            res_ci    <= 1'b0;
            res_bx    <= 1'b0;
        end else begin
            res_valid <= dma_req && !deny;
            res_fault <= dma_req && deny;
            res_addr  <= (dma_req && !deny) ? {lk_ppn, f_addr[PAGE_SH-1:0]} : '0;
            res_ci    <= dma_req && !deny && lk_ci;
            res_bx    <= dma_req && !deny && lk_bx;
        end
    end

    // R2: a result only appears the cycle after a request
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || res_fault) |-> $past(dma_req));

    // R2: the page offset passes through unchanged
    a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_addr[PAGE_SH-1:0] == $past(dma_addr[PAGE_SH-1:0]));

    // R3: success and fault never coincide
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_fault));

    // R4: a write to a protected page never translates
    a_r4_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_wr && lk_wp) |=> (res_fault && !res_valid));

    // R3: a non-01 type code always faults
    a_r3_type: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && lk_dt != DT_VALID) |=> res_fault);
endmodule

// File: tb/iotr_xlate_bench.sv
module iotr_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_sel, cpu_we;
    logic [10:0] cpu_idx;
    logic [31:0] cpu_wdata, cpu_rdata;
    logic        dma_req, dma_wr;
    logic [23:0] dma_addr;
    logic [4:0]  dev_aw;
    logic        res_valid, res_fault, res_ci, res_bx;
    logic [31:0] res_addr;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mdl [2048];

    always #10 clk = ~clk;

    iotr_xlate u_iotr_xlate (
        .clk(clk), .rst_n(rst_n),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_idx(cpu_idx),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .dma_req(dma_req), .dma_wr(dma_wr), .dma_addr(dma_addr), .dev_aw(dev_aw),
        .res_valid(res_valid), .res_fault(res_fault), .res_addr(res_addr),
        .res_ci(res_ci), .res_bx(res_bx)
    );

    // expected {valid, fault, ci, bx, addr}
    typedef logic [35:0] exp_t;

    function automatic logic [23:0] fold(input logic [23:0] a, input int w);
        logic [23:0] r = a;
        for (int i = 13; i < 24; i++) if (i >= w) r[i] = 1'b1;
        return r;
    endfunction

    function automatic exp_t predict(input logic [23:0] a, input logic wr, input int w);
        logic [23:0] f = fold(a, w);
        logic [31:0] d = mdl[f[23:13]];
        if (d[1:0] != 2'b01 || (wr && d[2])) return {1'b0, 1'b1, 2'b00, 32'h0};
        return {1'b1, 1'b0, d[6], d[5], d[31:13], f[12:0]};
    endfunction

    function automatic void model_upd(input logic [23:0] a, input logic wr, input int w);
        logic [23:0] f = fold(a, w);
        logic [31:0] d = mdl[f[23:13]];
        if (d[1:0] == 2'b01 && !(wr && d[2])) begin
            d[3] = 1'b1;
            if (wr) d[4] = 1'b1;
            mdl[f[23:13]] = d;
        end
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input int idx, input logic [31:0] v);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_idx = 11'(idx); cpu_wdata = v;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
        mdl[idx] = v;
    endtask

    task automatic cpu_check(input string req, input int idx);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_idx = 11'(idx);
        @(negedge clk);
        cpu_sel = 1'b0;
        check(req, 64'(cpu_rdata), 64'(mdl[idx]));
    endtask

    task automatic dma_op(input string req, input logic [23:0] a, input logic wr, input int w);
        exp_t e;
        @(negedge clk);
        e = predict(a, wr, w);
        dma_req = 1'b1; dma_wr = wr; dma_addr = a; dev_aw = 5'(w);
        model_upd(a, wr, w);
        @(negedge clk);
        dma_req = 1'b0;
        check(req, 64'({res_valid, res_fault, res_ci, res_bx, res_addr}), 64'(e));
    endtask

    function automatic int pool_idx(input int k);
        return (k < 8) ? k : 2032 + k;
    endfunction

    initial begin : watchdog
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        exp_t        eb [3];
        logic [23:0] ba [3];
        logic        bw [3];
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 2048; i++) mdl[i] = '0;
        cpu_sel = 0; cpu_we = 0; cpu_idx = 0; cpu_wdata = 0;
        dma_req = 0; dma_wr = 0; dma_addr = 0; dev_aw = 5'd24;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports and in the table
        check("R1", 64'({res_valid, res_fault, res_ci, res_bx, res_addr, cpu_rdata}), 64'h0);
        cpu_check("R1", 5);
        dma_op("R1", 24'h00_2000, 1'b0, 24);

        // R2 R5 R7: valid page read, then write, then status read-back
        cpu_write(3, {19'h12345, 6'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01});
        dma_op("R2", 24'h00_7ABC, 1'b0, 24);
        cpu_check("R7", 3);
        dma_op("R5", 24'h00_6001, 1'b1, 24);
        cpu_check("R7", 3);

        // R3 R8: type codes 00, 10, 11 fault and leave the entry alone
        cpu_write(4, {19'h0ABCD, 13'h0});
        dma_op("R3", 24'h00_8000, 1'b0, 24);
        cpu_write(4, {19'h0ABCD, 6'h0, 5'b10000, 2'b10});
        dma_op("R3", 24'h00_8010, 1'b1, 24);
        cpu_write(4, {19'h0ABCD, 6'h0, 5'b01000, 2'b11});
        dma_op("R3", 24'h00_9FFF, 1'b0, 24);
        cpu_check("R8", 4);

        // R4 R8: protected page reads translate, writes fault without status
        cpu_write(6, {19'h7FFFF, 6'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b01});
        dma_op("R4", 24'h00_C004, 1'b1, 24);
        cpu_check("R8", 6);
        dma_op("R4", 24'h00_C008, 1'b0, 24);
        dma_op("R4", 24'h00_C00C, 1'b1, 24);
        cpu_check("R8", 6);

        // R6: narrow devices land at the top of the space
        cpu_write(2047, {19'h55555, 6'h0, 5'b0, 2'b01});
        dma_op("R6", 24'h00_0123, 1'b0, 16);
        dma_op("R6", 24'h00_0000, 1'b0, 13);
        dma_op("R6", 24'h00_1FFF, 1'b0, 5);
        dma_op("R6", 24'h00_0123, 1'b0, 24);
        dma_op("R6", 24'h00_0456, 1'b0, 31);

        // R9: CPU write and status write-back to the same entry in one cycle
        @(negedge clk);
        eb[0] = predict(24'h00_6100, 1'b1, 24);
        dma_req = 1'b1; dma_wr = 1'b1; dma_addr = 24'h00_6100; dev_aw = 5'd24;
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_idx = 11'd3;
        cpu_wdata = {19'h00777, 6'h0, 5'b0, 2'b01};
        @(negedge clk);
        dma_req = 1'b0; cpu_sel = 1'b0; cpu_we = 1'b0;
        mdl[3] = {19'h00777, 6'h0, 5'b0, 2'b01};
        check("R9", 64'({res_valid, res_fault, res_ci, res_bx, res_addr}), 64'(eb[0]));
        cpu_check("R9", 3);

        // R10: CPU write and read-back, rdata holds between reads
        cpu_write(1000, 32'hDEAD_BEE5);
        cpu_check("R10", 1000);
        repeat (2) @(negedge clk);
        check("R10", 64'(cpu_rdata), 64'h0000_0000_DEAD_BEE5);

        // R11: three back-to-back requests, each seeing the previous update
        ba[0] = 24'h00_6010; bw[0] = 1'b0;
        ba[1] = 24'h00_C020; bw[1] = 1'b1;
        ba[2] = 24'h00_7030; bw[2] = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            eb[k] = predict(ba[k], bw[k], 24);
            model_upd(ba[k], bw[k], 24);
            dma_req = 1'b1; dma_wr = bw[k]; dma_addr = ba[k]; dev_aw = 5'd24;
            @(negedge clk);
            check("R11", 64'({res_valid, res_fault, res_ci, res_bx, res_addr}), 64'(eb[k]));
        end
        dma_req = 1'b0;
        cpu_check("R11", 3);

        // R2: random mix over a small page pool
        for (int k = 0; k < 16; k++) begin
            logic [31:0] v = $urandom;
            if ($urandom_range(3) != 0) v[1:0] = 2'b01;
            cpu_write(pool_idx(k), v);
        end
        for (int n = 0; n < 600; n++) begin
            int pick = int'($urandom_range(9));
            int k    = int'($urandom_range(15));
            if (pick < 2) begin
                logic [31:0] v = $urandom;
                if ($urandom_range(3) != 0) v[1:0] = 2'b01;
                cpu_write(pool_idx(k), v);
            end else if (pick < 3) begin
                cpu_check("R10", pool_idx(k));
            end else begin
                int ws [5] = '{24, 24, 16, 20, 14};
                int w = ws[$urandom_range(4)];
                logic [23:0] a = {11'(pool_idx(k)), 13'($urandom)};
                dma_op("R2", a, 1'($urandom), w);
            end
        end
        for (int k = 0; k < 16; k++) cpu_check("R7", pool_idx(k));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule